// File: doc/BRIEF.md
# Byte Lane Write Mask Resolver

This block sits in front of a 32-bit synchronous memory array and settles, at every rising clock edge, which byte lanes of the word take a write. It takes four write-control inputs, all active low: a global write strobe, a gate for the per-byte enables, one enable per byte lane, and the processor address strobe. From these it forms a registered lane mask. The mask is also widened to one enable per data bit. A registered flag tells the data path to turn its output drivers off while any lane is being written.

The global strobe writes the whole word and overrides every other input. Per-byte enables reach the mask only when their gate is low and the processor address strobe is high. An address-strobe cycle therefore never writes single bytes. Because all outputs are registered, the mask is valid in the cycle after the edge that sampled the controls. This matches write data captured by a register on that same edge.

Top module: `byte_we_resolver`

## Requirements
- R1: When gw_n is 0 at a rising edge, lane_wr_q becomes 4'b1111 after that edge, whatever bwe_n, adsp_n and bw_n hold.
- R2: When gw_n is 1 and bwe_n is 1 at a rising edge, lane_wr_q becomes 4'b0000 after that edge, for every value of bw_n.
- R3: When gw_n is 1, bwe_n is 0 and adsp_n is 1 at a rising edge, lane_wr_q bit i becomes 1 exactly when bw_n bit i was 0. Bit 0 is the lowest byte.
- R4: When gw_n is 1 and adsp_n is 0 at a rising edge, lane_wr_q becomes 4'b0000 after that edge, for every value of bwe_n and bw_n.
- R5: bit_wr_q bits 8*i+7 down to 8*i all equal lane_wr_q bit i, for i = 0 to 3. Lane 0 covers data bits 7:0 and lane 3 covers bits 31:24.
- R6: out_dis_q is 1 exactly when lane_wr_q is nonzero. With no write, both are 0.
- R7: All outputs are registered: they change only after a rising edge and reflect the inputs sampled there. While rst_n is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Gate for per-byte enables, active low |
| bw_n | input | 4 | Per-lane write enables, active low, bit 0 is the lowest byte |
| adsp_n | input | 1 | Processor address strobe, active low, blocks byte writes |
| lane_wr_q | output | 4 | Registered lane write mask, active high |
| bit_wr_q | output | 32 | Registered per-bit write mask, active high |
| out_dis_q | output | 1 | Registered output-driver disable, high while any lane writes |

## Verification
The bench applies all 128 combinations of the control inputs and compares every output with a value it computes from the priority rules.

- **Global strobe with address strobe low.** The bench checks that the whole word is still written. A design that let the address strobe block the global write would drop whole-word writes.
- **Gate high with per-byte enables active.** A design that ignored the gate would write stray bytes.
- **Address strobe low with the gate open.** A design that missed the strobe term would write bytes during address cycles.
- **Single-lane patterns.** These expose swapped lane order or misplaced bit fields in the widened mask.
- **Idle cycle after each write.** This catches a mask or disable flag that holds its previous value instead of clearing.

// File: rtl/byte_we_pkg.sv
package byte_we_pkg;

    localparam int unsigned LANES_DFLT  = 4;
    localparam int unsigned LANE_W_DFLT = 8;

    // Map a data bit index to the lane that owns it.
    function automatic int unsigned lane_of_bit(input int unsigned bit_idx,
                                                input int unsigned lane_w);
        return bit_idx / lane_w;
    endfunction

endpackage

// File: rtl/byte_we_lane.sv
module byte_we_lane (
    input  logic gw_n,
    input  logic bwe_n,
    input  logic adsp_n,
    input  logic bw_n_i,
    output logic we
);

    logic byte_path;

    always_comb begin
        // A per-byte enable reaches the write stage only when its gate is open
        // and no processor address-strobe cycle is in progress.
        byte_path = !bwe_n && adsp_n && !bw_n_i;
        we        = !gw_n || byte_path;
    end

endmodule

// File: rtl/byte_we_expand.sv
module byte_we_expand #(
    parameter int unsigned LANES  = byte_we_pkg::LANES_DFLT,
    parameter int unsigned LANE_W = byte_we_pkg::LANE_W_DFLT,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic [LANES-1:0]  lane_mask,
    output logic [DATA_W-1:0] bit_mask
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        localparam int unsigned OWNER = byte_we_pkg::lane_of_bit(b, LANE_W);
        assign bit_mask[b] = lane_mask[OWNER];
    end

endmodule

// File: rtl/byte_we_resolver.sv
module byte_we_resolver #(
    parameter int unsigned LANES  = byte_we_pkg::LANES_DFLT,
    parameter int unsigned LANE_W = byte_we_pkg::LANE_W_DFLT,
    localparam int unsigned DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic              adsp_n,
    output logic [LANES-1:0]  lane_wr_q,
    output logic [DATA_W-1:0] bit_wr_q,
    output logic              out_dis_q
);

    typedef struct packed {
        logic [LANES-1:0]  lane;
        logic [DATA_W-1:0] bits;
        logic              dis;
    } wr_state_t;

    logic [LANES-1:0]  lane_d;
    logic [DATA_W-1:0] bits_d;
    wr_state_t         st_d;
    wr_state_t         st_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        byte_we_lane u_lane (
            .gw_n   (gw_n),
            .bwe_n  (bwe_n),
            .adsp_n (adsp_n),
            .bw_n_i (bw_n[l]),
            .we     (lane_d[l])
        );
    end

    byte_we_expand #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_expand (
        .lane_mask (lane_d),
        .bit_mask  (bits_d)
    );

    always_comb begin
        st_d      = '0;
        st_d.lane = lane_d;
        st_d.bits = bits_d;
        st_d.dis  = |lane_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_wr_q = st_q.lane;
    assign bit_wr_q  = st_q.bits;
    assign out_dis_q = st_q.dis;

    // R1
    global_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gw_n |=> (lane_wr_q == {LANES{1'b1}}));

    // R2
    gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |=> (lane_wr_q == '0));

    // R3
    byte_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && !bwe_n && adsp_n) |=> (lane_wr_q == ~$past(bw_n)));

    // R4
    strobe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && !adsp_n) |=> (lane_wr_q == '0));

    // R5
    for (genvar c = 0; c < DATA_W; c++) begin : g_bit_chk
        bit_follows_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bit_wr_q[c] == lane_wr_q[c / LANE_W]);
    end

    // R6
    out_dis_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis_q == (lane_wr_q != '0));

endmodule

// File: tb/byte_we_resolver_bench.sv
`timescale 1ns/1ps
module byte_we_resolver_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gw_n = 1'b1;
    logic        bwe_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic        adsp_n = 1'b1;
    logic [3:0]  lane_wr_q;
    logic [31:0] bit_wr_q;
    logic        out_dis_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    byte_we_resolver u_byte_we_resolver (
        .clk       (clk),
        .rst_n     (rst_n),
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .adsp_n    (adsp_n),
        .lane_wr_q (lane_wr_q),
        .bit_wr_q  (bit_wr_q),
        .out_dis_q (out_dis_q)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] model_mask(input logic g, input logic b,
                                              input logic a, input logic [3:0] w);
        if (!g) return 4'hF;     // R1
        if (b) return 4'h0;      // R2
        if (!a) return 4'h0;     // R4
        return ~w;               // R3
    endfunction

    function automatic logic [31:0] model_bits(input logic [3:0] m);
        logic [31:0] r = '0;
        for (int i = 0; i < 4; i++)
            if (m[i]) r = r | (32'hFF << (8 * i));
        return r;
    endfunction

    task automatic apply_and_check(input logic g, input logic b,
                                   input logic a, input logic [3:0] w);
        logic [3:0] exp_m;
        @(negedge clk);
        gw_n = g; bwe_n = b; adsp_n = a; bw_n = w;
        exp_m = model_mask(g, b, a, w);
        @(negedge clk);
        if (!g)             check("R1 lane mask", {28'd0, lane_wr_q}, {28'd0, exp_m});
        else if (b)         check("R2 lane mask", {28'd0, lane_wr_q}, {28'd0, exp_m});
        else if (!a)        check("R4 lane mask", {28'd0, lane_wr_q}, {28'd0, exp_m});
        else                check("R3 lane mask", {28'd0, lane_wr_q}, {28'd0, exp_m});
        check("R5 bit mask", bit_wr_q, model_bits(exp_m));
        check("R6 out disable", {31'd0, out_dis_q}, {31'd0, exp_m != 4'h0});
    endtask

    initial begin
        #1;
        // R7: outputs are held at zero while reset is asserted, even with writes requested.
        gw_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset mask", {28'd0, lane_wr_q}, 32'd0);
        check("R7 reset bits", bit_wr_q, 32'd0);
        check("R7 reset disable", {31'd0, out_dis_q}, 32'd0);
        gw_n = 1'b1;
        rst_n = 1'b1;

        // R7: a change between edges does not reach the outputs until the next edge.
        @(negedge clk);
        gw_n = 1'b0;
        #0.5;
        check("R7 no change before edge", {28'd0, lane_wr_q}, 32'd0);
        @(negedge clk);
        check("R7 update after edge", {28'd0, lane_wr_q}, 32'hF);

        for (int g = 0; g < 2; g++)
            for (int b = 0; b < 2; b++)
                for (int a = 0; a < 2; a++)
                    for (int w = 0; w < 16; w++) begin
                        apply_and_check(g[0], b[0], a[0], w[3:0]);
                        // R6: idle cycle after each pattern clears mask and flag
                        apply_and_check(1'b1, 1'b1, 1'b1, 4'hF);
                    end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule